// File: doc/BRIEF.md
# Retriggerable Gated One-Shot

This block produces a single high pulse of programmable length whenever one of three gated edge conditions appears on its inputs. It has two gate inputs, one active-low (`trig_a_n`) and one active-high (`trig_b`), and an active-low clear (`clr_n`). A down-counter times the pulse from the `pulse_len` value in place of an external timing network. The block drives complementary outputs `pulse_q` and `pulse_qn`.

All three control inputs may be asynchronous, slow or noisy. Each passes through a synchronizer before edge detection, so a qualifying transition produces exactly one trigger. A new trigger during an active pulse reloads the full length. Triggers that keep arriving can therefore hold the output high indefinitely. Clear overrides everything, and while it is low no trigger is accepted.

The pins are plain control levels with no streaming data, so there is no valid/ready handshake and no back-pressure. Two independent channels are simply two instances.

Top module: `oneshot_pulse_gen`

## Requirements
- R1: When `trig_b` rises while `trig_a_n` is low and `clr_n` is high, a pulse starts.
- R2: When `trig_a_n` falls while `trig_b` is high and `clr_n` is high, a pulse starts.
- R3: When `clr_n` rises while `trig_a_n` is low and `trig_b` is high, a pulse starts. A `clr_n` rise with `trig_a_n` high starts nothing.
- R4: Suppose an input change is set up before clock edge E0. The resulting pulse raises `pulse_q` on edge E2. `pulse_q` then stays high for exactly `pulse_len` cycles, with no clear and no further trigger. The maximum value 2^LEN_W-1 is included.
- R5: A trigger during an active pulse restarts the full length from that trigger. Triggers spaced closer than the length keep `pulse_q` high without a gap.
- R6: `clr_n` low forces `pulse_q` low two edges after the change, whatever the gates do. While the synchronized clear is low, gate edges start no pulse. A gate edge that reaches the edge detector in the same cycle as a clear assertion also starts no pulse.
- R7: A trigger with `pulse_len` equal to 0 gives no pulse, and it ends an active pulse at the edge where it loads.
- R8: During reset `pulse_q` is 0 and `pulse_qn` is 1. After reset is released, no pulse appears, whatever levels the inputs hold.
- R9: `pulse_qn` is the complement of `pulse_q` in every cycle.
- R10: None of the following starts a pulse: holding levels, `trig_b` rising with `trig_a_n` high, `trig_a_n` falling with `trig_b` low, `trig_a_n` rising, or `trig_b` falling. Each qualifying transition starts only one pulse.
- R11: `pulse_len` is taken at the edge where a trigger loads the counter. Changing it later does not alter the pulse in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_a_n | input | 1 | Active-low gate/trigger input, asynchronous |
| trig_b | input | 1 | Active-high gate/trigger input, asynchronous |
| clr_n | input | 1 | Active-low clear, asynchronous; its release can also trigger |
| pulse_len | input | LEN_W | Pulse length in clock cycles |
| pulse_q | output | 1 | Pulse output, high while timing |
| pulse_qn | output | 1 | Complement of `pulse_q` |

## Verification
The bench builds the block with `LEN_W = 4` and `SYNC_STAGES = 2`. The 4-bit length makes the largest pulse, 15 cycles, short enough to run to its end, alongside the length-0 and length-1 extremes. Two synchronizer stages fix the trigger-to-output latency at two edges. The scoreboard can then predict every cycle of `pulse_q` and `pulse_qn` from the requirement-level trigger rules, including retrigger chains, clear overlapping a gate edge, and the levels held across reset release.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  // Bundle of the three asynchronous control lines, kept together through sync
  typedef struct packed {
    logic a_n;
    logic b;
    logic clr_n;
  } gate_lines_t;
endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], din[i]};
    end
    assign dout[i] = sh[STAGES-1];
  end
endmodule

// File: rtl/os_edge_qual.sv
module os_edge_qual
  import oneshot_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  gate_lines_t now_s,
  output logic        trig,
  output logic        kill
);
  localparam int WARM = SYNC_STAGES + 1;
  localparam int CW   = $clog2(WARM + 1);

  gate_lines_t     prev_s;
  logic [CW-1:0]   warm;
  logic            ready;
  logic            b_rise, a_fall, c_rise, gates_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_s <= '0;
      warm   <= '0;
    end else begin
      prev_s <= now_s;
      if (!ready) warm <= warm + 1'b1;
    end
  end

  // edges are ignored until the sync chain and edge register hold real input
  assign ready    = (warm == CW'(WARM));
  assign b_rise   = now_s.b & ~prev_s.b;
  assign a_fall   = ~now_s.a_n & prev_s.a_n;
  assign c_rise   = now_s.clr_n & ~prev_s.clr_n;
  assign gates_on = ~now_s.a_n & now_s.b;

  assign trig = ready & now_s.clr_n &
                ((b_rise & ~now_s.a_n) | (a_fall & now_s.b) | (c_rise & gates_on));
  assign kill = ~now_s.clr_n;
endmodule

// File: rtl/os_timer.sv
module os_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             kill,
  input  logic [LEN_W-1:0] pulse_len,
  output logic [LEN_W-1:0] cnt,
  output logic             q,
  output logic             qn
);
  logic [LEN_W-1:0] cnt_next;

  always_comb begin
    if (kill)              cnt_next = '0;
    else if (trig)         cnt_next = pulse_len;
    else if (cnt != '0)    cnt_next = cnt - 1'b1;
    else                   cnt_next = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      q   <= 1'b0;
      qn  <= 1'b1;
    end else begin
      cnt <= cnt_next;
      q   <= (cnt_next != '0);
      qn  <= (cnt_next == '0);
    end
  end
endmodule

// File: rtl/oneshot_pulse_gen.sv
module oneshot_pulse_gen
  import oneshot_pkg::*;
#(
  parameter int LEN_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_a_n,
  input  logic             trig_b,
  input  logic             clr_n,
  input  logic [LEN_W-1:0] pulse_len,
  output logic             pulse_q,
  output logic             pulse_qn
);
  localparam int NLINES = $bits(gate_lines_t);

  gate_lines_t      raw, synced;
  logic             trig, kill;
  logic [LEN_W-1:0] cnt;

  assign raw = '{a_n: trig_a_n, b: trig_b, clr_n: clr_n};

  os_sync #(.STAGES(SYNC_STAGES), .W(NLINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw), .dout(synced)
  );

  os_edge_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
    .clk(clk), .rst_n(rst_n), .now_s(synced), .trig(trig), .kill(kill)
  );

  os_timer #(.LEN_W(LEN_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .trig(trig), .kill(kill), .pulse_len(pulse_len),
    .cnt(cnt), .q(pulse_q), .qn(pulse_qn)
  );
endmodule

// File: rtl/os_chk.sv
module os_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig,
  input logic             kill,
  input logic [LEN_W-1:0] pulse_len,
  input logic [LEN_W-1:0] cnt,
  input logic             pulse_q,
  input logic             pulse_qn
);
  // R6
  clear_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !pulse_q);

  // R4
  load_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !kill && pulse_len != '0) |=> (pulse_q && cnt == $past(pulse_len)));

  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !kill && pulse_len == '0) |=> !pulse_q);

  // R4
  hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !kill && cnt > 1) |=> (pulse_q && cnt == $past(cnt) - 1'b1));

  // R9
  compl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q != pulse_qn);
endmodule

bind oneshot_pulse_gen os_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .kill(kill), .pulse_len(pulse_len),
  .cnt(cnt), .pulse_q(pulse_q), .pulse_qn(pulse_qn)
);

// File: tb/sim_oneshot_pulse_gen.sv
`timescale 1ns/1ps
module sim_oneshot_pulse_gen;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          a_n = 1'b0, b = 1'b1, c_n = 1'b1;
  logic [LW-1:0] len = '0;
  logic [LW-1:0] next_len = '0;
  logic          q, qn;

  always #4 clk = ~clk;

  oneshot_pulse_gen #(.LEN_W(LW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_a_n(a_n), .trig_b(b), .clr_n(c_n),
    .pulse_len(len), .pulse_q(q), .pulse_qn(qn)
  );

  int    checks = 0, errors = 0;
  bit    finished = 0;
  bit    exp_q[$];
  string exp_tag[$];
  string cur = "R8";

  // requirement-level model state: last driven levels and a 2-deep event delay
  bit m_a = 0, m_b = 1, m_c = 1;
  bit p1_t = 0, p1_k = 0, p2_t = 0, p2_k = 0;
  int m_cnt = 0;

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // driver: apply one cycle of inputs, push expected output for that cycle
  task automatic step(bit na, bit nb, bit nc);
    bit t, k;
    @(negedge clk);
    a_n = na; b = nb; c_n = nc; len = next_len;
    k = !nc;
    t = nc && ((nb && !m_b && !na) ||            // R1
               (!na && m_a && nb) ||             // R2
               (!m_c && !na && nb));             // R3
    m_a = na; m_b = nb; m_c = nc;
    if (p2_k)           m_cnt = 0;
    else if (p2_t)      m_cnt = int'(len);
    else if (m_cnt > 0) m_cnt--;
    p2_t = p1_t; p2_k = p1_k; p1_t = t; p1_k = k;
    exp_q.push_back(m_cnt != 0);
    exp_tag.push_back(cur);
  endtask

  task automatic hold(int n);
    for (int i = 0; i < n; i++) step(m_a, m_b, m_c);
  endtask

  task automatic trig_b_edge();
    step(m_a, 1'b0, m_c);
    step(m_a, 1'b1, m_c);
  endtask

  // monitor: compare away from the clock edge
  bit    mon_e;
  string mon_tag;
  always @(posedge clk) begin
    #2;
    if (exp_q.size() != 0) begin
      mon_e   = exp_q.pop_front();
      mon_tag = exp_tag.pop_front();
      checks++;
      // R9: q_n checked against the complement in every cycle
      if (q !== mon_e || qn !== !mon_e) begin
        errors++;
        $display("FAIL %s/R9: q=%b qn=%b expected q=%b qn=%b at %0t",
                 mon_tag, q, qn, mon_e, !mon_e, $time);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run hung, expected completion");
    report();
  end

  initial begin
    // R8: reset state with worst-case enabled levels held
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (q !== 1'b0 || qn !== 1'b1) begin
      errors++;
      $display("FAIL R8: q=%b qn=%b expected q=0 qn=1", q, qn);
    end
    @(negedge clk) rst_n = 1'b1;
    cur = "R8"; next_len = 4'd5;
    hold(8);

    cur = "R10";
    step(1, 1, 1);          // A rises
    step(1, 0, 1);          // B falls
    hold(3);
    step(1, 1, 1);          // B rises with A high
    step(1, 0, 1);
    step(0, 0, 1);          // A falls with B low
    hold(4);

    cur = "R1";
    step(0, 1, 1);
    hold(8);

    cur = "R2";
    step(1, 1, 1);
    hold(2);
    step(0, 1, 1);
    hold(8);

    cur = "R5";
    next_len = 4'd4;
    for (int i = 0; i < 6; i++) trig_b_edge();
    hold(8);
    next_len = 4'd6;
    trig_b_edge();
    hold(3);
    trig_b_edge();
    hold(10);

    cur = "R11";
    next_len = 4'd7;
    trig_b_edge();
    hold(3);
    next_len = 4'd2;
    hold(10);

    cur = "R6";
    next_len = 4'd9;
    trig_b_edge();
    hold(3);
    step(0, 1, 0);          // clear cuts the pulse
    hold(2);
    step(0, 0, 0);
    step(0, 1, 0);          // B rises while cleared
    step(1, 1, 0);
    step(0, 1, 0);          // A falls while cleared
    hold(3);

    cur = "R3";
    step(0, 1, 1);          // clear released with gates enabled
    hold(12);

    cur = "R6";
    step(0, 0, 1);
    hold(2);
    step(0, 1, 0);          // B rises in the same cycle clear asserts
    hold(3);
    cur = "R3";
    step(1, 1, 0);
    step(1, 1, 1);          // clear released with A high
    hold(4);

    cur = "R7";
    next_len = 4'd0;
    step(1, 0, 1);
    step(0, 0, 1);
    step(0, 1, 1);
    hold(4);
    next_len = 4'd8;
    trig_b_edge();
    hold(3);
    next_len = 4'd0;
    trig_b_edge();          // zero-length trigger ends the active pulse
    hold(5);

    cur = "R4";
    next_len = 4'd15;
    trig_b_edge();
    hold(20);
    next_len = 4'd1;
    trig_b_edge();
    hold(4);

    while (exp_q.size() != 0) @(posedge clk);
    @(posedge clk); #3;
    report();
  end
endmodule